// File: doc/BRIEF.md
# Triple-Oversampled Serial Byte Receiver

This block recovers bytes from an asynchronous serial line. An enable pulse `os_tick` arrives at three times the baud rate, and the line is sampled once on each pulse. A frame is ten bit periods long: one start bit, eight data bits with the least significant bit first, and one stop bit. At three samples per bit that is 30 samples, which the block takes as two back-to-back words of 15 samples each. Each data bit is taken from the middle sample of its group of three.

The serial input first passes through a two-flop synchroniser. In state ST_IDLE the controller waits for a tick on which the synchronised line is low. That sample is treated as the first start-bit sample, and the transition START takes the controller to ST_HALF_A. After 15 samples the transition SPLIT moves it to ST_HALF_B with no new trigger. After 15 more samples the transition FINISH returns it to ST_IDLE. Because the stop bit leaves the line high, the next frame can begin only at the next start bit.

A finished byte sits in a one-entry holding buffer with a full flag until a consumer pulses `rd_strobe`. A frame that completes while the buffer is still full is dropped. The stop samples are captured but not checked, and a start edge that lands exactly on a sampling edge gets no correction.

Top module: `uart3x_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `byte_full` is 0 and `rx_byte` is 0x00.
- R2: A tick on which the synchronised line is high, in ST_IDLE, starts nothing: the controller stays in ST_IDLE and `byte_full` does not change.
- R3: A tick with the synchronised line low in ST_IDLE counts as sample 0 of a frame. A frame is complete on the tick that takes sample 29, and not on any earlier tick.
- R4: Data bit k (k = 0..7) of `rx_byte` is the line level at sample 4+3k, the middle sample of the k-th triple after the start triple. The byte is therefore least significant bit first.
- R5: After sample 14, sample 15 onward is captured on the following ticks whatever the line level, so a second half that is all high still completes the frame.
- R6: After sample 29 the controller is in ST_IDLE and needs a low sample before a new frame starts. A line held high after a frame starts no frame.
- R7: A completed frame sets `byte_full` on the clock edge of its last sample tick. A `rd_strobe` pulse while full clears `byte_full` on the next edge. A `rd_strobe` pulse while empty has no effect.
- R8: A frame that completes while `byte_full` is 1 is discarded. `rx_byte` keeps its held value.
- R9: Only the middle sample of each triple matters. The outer two samples of a data triple have no effect on the byte, which covers a frame captured one sample early.
- R10: The stop samples (27..29) are not checked. A frame whose stop samples are low still sets `byte_full` with the recovered byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Asynchronous serial data line, idle high |
| os_tick | input | 1 | One-cycle enable at three times the baud rate |
| rd_strobe | input | 1 | One-cycle read of the held byte |
| rx_byte | output | 8 | Held received byte |
| byte_full | output | 1 | A byte is held and has not been read |

## Verification
The checker watches the state transitions on every cycle: a low idle tick leads to ST_HALF_A, a high idle tick stays in ST_IDLE, and ST_HALF_A moves to ST_HALF_B after sample 14 with no trigger. It also checks on every cycle that the full flag rises only with a completed frame, that a read clears it, and that the held byte stays stable while full. Which sample supplies each data bit, the discarding of a frame that arrives while full, the stop samples going unchecked, and the frame ending exactly at the 30th sample can be shown only by the bench's frame scenarios, which compare recovered bytes against sample patterns built independently.

// File: rtl/uart3x_pkg.sv
package uart3x_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HALF_A = 2'd1,
        ST_HALF_B = 2'd2
    } rx_state_t;
endpackage

// File: rtl/uart3x_sync.sv
module uart3x_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart3x_fsm.sv
module uart3x_fsm
    import uart3x_pkg::*;
#(
    parameter int FRAME_LEN = 30,
    parameter int HALF_LEN  = 15,
    localparam int IDX_W    = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line,
    output rx_state_t        state,
    output logic [IDX_W-1:0] sample_idx,
    output logic             cap_en,
    output logic             frame_done
);
    localparam logic [IDX_W-1:0] LAST_A = IDX_W'(HALF_LEN - 1);
    localparam logic [IDX_W-1:0] LAST_B = IDX_W'(FRAME_LEN - 1);

    rx_state_t        st_q, st_nx;
    logic [IDX_W-1:0] idx_q, idx_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_nx;
            idx_q <= idx_nx;
        end
    end

    // Next-state logic
    always_comb begin
        st_nx  = st_q;
        idx_nx = idx_q;
        unique case (st_q)
            ST_IDLE: begin
                if (tick && !line) begin          // START
                    st_nx  = ST_HALF_A;
                    idx_nx = IDX_W'(1);
                end
            end
            ST_HALF_A: begin
                if (tick) begin
                    idx_nx = idx_q + 1'b1;
                    if (idx_q == LAST_A) st_nx = ST_HALF_B;   // SPLIT
                end
            end
            ST_HALF_B: begin
                if (tick) begin
                    if (idx_q == LAST_B) begin    // FINISH
                        st_nx  = ST_IDLE;
                        idx_nx = '0;
                    end else begin
                        idx_nx = idx_q + 1'b1;
                    end
                end
            end
            default: begin
                st_nx  = ST_IDLE;
                idx_nx = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        cap_en     = tick && ((st_q != ST_IDLE) || !line);
        frame_done = tick && (st_q == ST_HALF_B) && (idx_q == LAST_B);
    end

    assign state      = st_q;
    assign sample_idx = idx_q;
endmodule

// File: rtl/uart3x_extract.sv
module uart3x_extract #(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 3,
    parameter int IDX_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_en,
    input  logic [IDX_W-1:0]     sample_idx,
    input  logic                 line,
    output logic [DATA_BITS-1:0] data
);
    // Data bit k comes from the centre sample of triple k+1 (triple 0 is start)
    for (genvar k = 0; k < DATA_BITS; k++) begin : g_bit
        localparam logic [IDX_W-1:0] MID = IDX_W'(OVS * (k + 1) + OVS / 2);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             data[k] <= 1'b0;
            else if (cap_en && sample_idx == MID)   data[k] <= line;
        end
    end
endmodule

// File: rtl/uart3x_holdbuf.sv
module uart3x_holdbuf #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_done,
    input  logic [DATA_BITS-1:0] data_in,
    input  logic                 rd,
    output logic [DATA_BITS-1:0] data_out,
    output logic                 full
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out <= '0;
            full     <= 1'b0;
        end else if (frame_done && !full) begin
            data_out <= data_in;
            full     <= 1'b1;
        end else if (rd) begin
            full     <= 1'b0;
        end
    end
endmodule

// File: rtl/uart3x_rx.sv
module uart3x_rx
    import uart3x_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 3,
    parameter int SYNC_LEN  = 2,
    localparam int FRAME_LEN = OVS * (DATA_BITS + 2),
    localparam int HALF_LEN  = FRAME_LEN / 2,
    localparam int IDX_W     = $clog2(FRAME_LEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_line,
    input  logic                 os_tick,
    input  logic                 rd_strobe,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 byte_full
);
    logic                 rx_s;
    rx_state_t            fsm_state;
    logic [IDX_W-1:0]     sample_idx;
    logic                 cap_en;
    logic                 frame_done;
    logic [DATA_BITS-1:0] frame_data;

    uart3x_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s)
    );

    uart3x_fsm #(.FRAME_LEN(FRAME_LEN), .HALF_LEN(HALF_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(rx_s),
        .state(fsm_state), .sample_idx(sample_idx),
        .cap_en(cap_en), .frame_done(frame_done)
    );

    uart3x_extract #(.DATA_BITS(DATA_BITS), .OVS(OVS), .IDX_W(IDX_W)) u_extract (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .sample_idx(sample_idx),
        .line(rx_s), .data(frame_data)
    );

    uart3x_holdbuf #(.DATA_BITS(DATA_BITS)) u_buf (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .data_in(frame_data),
        .rd(rd_strobe), .data_out(rx_byte), .full(byte_full)
    );
endmodule

// File: rtl/uart3x_rx_chk.sv
module uart3x_rx_chk
    import uart3x_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int FRAME_LEN = 30,
    parameter int HALF_LEN  = 15,
    parameter int IDX_W     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 os_tick,
    input logic                 rd_strobe,
    input logic                 rx_s,
    input rx_state_t            fsm_state,
    input logic [IDX_W-1:0]     sample_idx,
    input logic                 frame_done,
    input logic [DATA_BITS-1:0] rx_byte,
    input logic                 byte_full
);
    localparam logic [IDX_W-1:0] LAST_A = IDX_W'(HALF_LEN - 1);
    localparam logic [IDX_W-1:0] LAST_B = IDX_W'(FRAME_LEN - 1);

    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (!byte_full && rx_byte == '0));

    assert_idle_high_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && os_tick && rx_s) |=> fsm_state == ST_IDLE);

    assert_low_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && os_tick && !rx_s) |=> fsm_state == ST_HALF_A);

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_idx <= LAST_B);

    assert_second_half_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_HALF_A && os_tick && sample_idx == LAST_A) |=> fsm_state == ST_HALF_B);

    assert_back_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_HALF_B && os_tick && sample_idx == LAST_B) |=> fsm_state == ST_IDLE);

    assert_full_from_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_full) |-> $past(frame_done));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_full && rd_strobe) |=> !byte_full);

    assert_hold_while_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_full && $past(byte_full)) |-> $stable(rx_byte));
endmodule

bind uart3x_rx uart3x_rx_chk #(
    .DATA_BITS(DATA_BITS), .FRAME_LEN(FRAME_LEN), .HALF_LEN(HALF_LEN), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rd_strobe(rd_strobe),
    .rx_s(rx_s), .fsm_state(fsm_state), .sample_idx(sample_idx),
    .frame_done(frame_done), .rx_byte(rx_byte), .byte_full(byte_full)
);

// File: tb/uart3x_rx_bench.sv
module uart3x_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_byte;
    logic       byte_full;

    int  checks = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    uart3x_rx u_uart3x_rx (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
        .rd_strobe(rd_strobe), .rx_byte(rx_byte), .byte_full(byte_full)
    );

    // Upper byte: stimulus byte, lower byte: expected byte
    localparam logic [15:0] VEC [6] = '{16'h0000, 16'hFFFF, 16'hA5A5,
                                        16'h5A5A, 16'h0101, 16'h8080};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One sample: line settles past the synchroniser, then a single tick
    task automatic put_sample(input logic v);
        @(negedge clk) rx_line = v;
        repeat (2) @(negedge clk);
        os_tick = 1'b1;
        @(negedge clk) os_tick = 1'b0;
    endtask

    // Sample j of the frame is bit j; start 0..2, data k at 3+3k..5+3k, stop 27..29
    function automatic logic [29:0] mk_frame(input logic [7:0] b, input logic stop_v);
        logic [29:0] s;
        s[2:0] = 3'b000;
        for (int k = 0; k < 8; k++) s[3 + 3*k +: 3] = {3{b[k]}};
        s[29:27] = {3{stop_v}};
        return s;
    endfunction

    task automatic send_samples(input logic [29:0] s, input int n_first, input int n_last);
        for (int j = n_first; j <= n_last; j++) put_sample(s[j]);
    endtask

    task automatic read_byte();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put_sample(1'b1);
    endtask

    initial begin
        logic [29:0] f;
        repeat (3) @(negedge clk);
        chk("R1 full during reset", byte_full, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 full after reset", byte_full, 0);
        chk("R1 byte after reset", rx_byte, 0);

        // R2: high line at idle ticks starts nothing
        idle(40);
        chk("R2 idle high no frame", byte_full, 0);

        // R7: read while empty has no effect
        read_byte();
        chk("R7 read while empty", byte_full, 0);

        // Table of frames (R4, R5, R7)
        for (int v = 0; v < 6; v++) begin
            send_samples(mk_frame(VEC[v][15:8], 1'b1), 0, 29);
            chk("R4 table byte", rx_byte, VEC[v][7:0]);
            chk("R7 table full set", byte_full, 1);
            read_byte();
            chk("R7 table read clears", byte_full, 0);
            idle(2);
        end

        // R3: frame completes exactly on sample 29
        f = mk_frame(8'h69, 1'b1);
        send_samples(f, 0, 28);
        chk("R3 not complete at sample 28", byte_full, 0);
        send_samples(f, 29, 29);
        chk("R3 complete at sample 29", byte_full, 1);
        chk("R3 byte", rx_byte, 8'h69);

        // R6: line high after a frame starts nothing new
        read_byte();
        idle(45);
        chk("R6 no retrigger after stop", byte_full, 0);

        // R8: second frame while full discarded
        send_samples(mk_frame(8'h3C, 1'b1), 0, 29);
        chk("R8 first byte", rx_byte, 8'h3C);
        idle(3);
        send_samples(mk_frame(8'h77, 1'b1), 0, 29);
        chk("R8 held byte kept", rx_byte, 8'h3C);
        chk("R8 still full", byte_full, 1);
        read_byte();
        chk("R8 read clears", byte_full, 0);
        send_samples(mk_frame(8'h77, 1'b1), 0, 29);
        chk("R8 next byte accepted", rx_byte, 8'h77);
        read_byte();

        // R9: outer samples of each data triple inverted; middle decides
        f = mk_frame(8'h96, 1'b1);
        for (int k = 0; k < 8; k++) begin
            f[3 + 3*k]     = ~f[4 + 3*k];
            f[3 + 3*k + 2] = ~f[4 + 3*k];
        end
        idle(2);
        send_samples(f, 0, 29);
        chk("R9 middle sample only", rx_byte, 8'h96);
        read_byte();

        // R9: frame seen one sample early (start sample count 2), middle kept
        f = {1'b1, mk_frame(8'hC3, 1'b1)[29:1]};
        idle(2);
        send_samples(f, 0, 29);
        chk("R9 early capture full", byte_full, 1);
        chk("R9 early capture byte", rx_byte, 8'hC3);
        read_byte();

        // R10: stop samples low still accepted
        idle(2);
        send_samples(mk_frame(8'h5C, 1'b0), 0, 29);
        chk("R10 bad stop full", byte_full, 1);
        chk("R10 bad stop byte", rx_byte, 8'h5C);
        put_sample(1'b1);
        read_byte();
        chk("R10 read clears", byte_full, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule